// File: doc/BRIEF.md
# Flash Erase Interlock Sequencer

This block stands between the system bus and an on-chip flash array and decides when erase high voltage may be switched on. Erase cannot start from one stray write. Software first writes the control register with both the erase-select bit and the setup bit set. It then makes a separate dummy write to any array location. Only after these two writes will a write of the high-voltage bit start an erase pulse. A register write does not count as the dummy array write.

While a pulse is active, the high-voltage output is on, the array is reported busy, and array reads get an error response instead of data. A programmable down-counter measures the pulse width and raises a sticky done flag when it reaches zero. When the pulse ends, the block enters a margin-read mode in which software verifies the erase. From there it can pulse again or abandon the sequence. The current state is always visible on a 3-bit status output and through a status register.

Top module: `flash_erase_seq`

## Requirements
- R1: While `rst` (synchronous, active high, master reset) is high and after it falls, the state is normal (code 0). `hv_en`, `array_busy`, `margin_mode` and `pulse_done` are low, and every register reads 0.
- R2: In normal state, a control-register write (register space, offset 0) with bit 2 (erase select) = 1 and bit 1 (setup) = 1 moves the block to armed (code 1) on the next clock.
- R3: In armed state, any write to array space moves the block to ready (code 2). A register write that does not clear setup leaves the block armed.
- R4: In armed state, a control write with bit 0 (high-voltage request) = 1 does not raise `hv_en`, and the block stays armed.
- R5: In ready state, a control write with bit 1 = 1 and bit 0 = 1 enters pulse (code 3). `hv_en` and `array_busy` are high only in pulse state.
- R6: In pulse state, an array read returns `rd_err` = 1 one cycle later. Control writes can change only bit 0: a write with setup = 0 and bit 0 = 1 leaves the block in pulse.
- R7: Pulse state ends in margin (code 4, `margin_mode` high, `hv_en` low) on a control write with bit 0 = 0, on `stop_req`, or on `sys_rst`.
- R8: In margin state, a control write with bits 1 and 0 set starts another pulse.
- R9: A control write with bit 1 = 0 returns the block to normal from armed, ready or margin. Master reset returns it to normal from any state, including pulse.
- R10: The width register (offset 1) and the config register (offset 2: prescaler in bits 2:0, protect field in bits 15:8) accept writes only in normal state. Writes to them in other states are ignored.
- R11: On pulse entry the timer loads the width value and clears `pulse_done`. If the prescaler P is nonzero, the timer decrements once every P cycles while in pulse, and `pulse_done` sets one cycle after it reaches zero and then stays set until the next pulse entry. If P = 0, `pulse_done` never sets.
- R12: A register read returns the register contents on `rd_data` one cycle later in every state. The control register reads {bit2 select, bit1 setup, bit0 = in pulse}. The status register (offset 3) reads the state code in bits 2:0 and the done flag in bit 4. An array read outside pulse state returns `arr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high |
| sys_rst | input | 1 | System reset; ends an active pulse |
| stop_req | input | 1 | Stop request; ends an active pulse |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_space | input | 1 | 1 = register space, 0 = array space |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| arr_rdata | input | 16 | Data from the flash array |
| rd_data | output | 16 | Registered read data |
| rd_err | output | 1 | Array read refused during pulse |
| hv_en | output | 1 | Erase high-voltage enable |
| array_busy | output | 1 | Array unavailable for access |
| margin_mode | output | 1 | Margin-read verification active |
| state_o | output | 3 | Current state code |
| pulse_done | output | 1 | Sticky pulse-timer done flag |

## Verification
If the block holds the wrong internal state, `state_o` shows it on the first clock after the write that caused it. If the block skips the interlock, `hv_en` rises one cycle too early in the sequence, for example right after arming without the dummy array write. A timer fault shows up only at the end of the pulse, as a `pulse_done` edge that arrives early, late or never. For that reason the timer checks bracket that edge to the cycle. Faults in register gating show up only later, on a readback that returns a value written outside normal state.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_ARMED  = 3'd1,
    ST_READY  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_MARGIN = 3'd4
  } fe_state_t;

  localparam int CTRL_HV_BIT    = 0;
  localparam int CTRL_SETUP_BIT = 1;
  localparam int CTRL_SEL_BIT   = 2;

  localparam logic [1:0] OFS_CTRL  = 2'd0;
  localparam logic [1:0] OFS_WIDTH = 2'd1;
  localparam logic [1:0] OFS_CFG   = 2'd2;
  localparam logic [1:0] OFS_STAT  = 2'd3;

  localparam int CFG_PROT_LSB  = 8;
  localparam int STAT_DONE_BIT = 4;
endpackage

// File: rtl/flash_erase_fsm.sv
module flash_erase_fsm
  import flash_erase_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ctrl_wr,
  input  logic      wd_hv,
  input  logic      wd_setup,
  input  logic      wd_sel,
  input  logic      arr_wr,
  input  logic      stop_req,
  input  logic      sys_rst,
  output fe_state_t state,
  output logic      pulse_start
);
  fe_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_NORMAL: if (ctrl_wr && wd_sel && wd_setup) nxt = ST_ARMED;
      ST_ARMED: begin
        if (ctrl_wr && !wd_setup) nxt = ST_NORMAL;
        else if (arr_wr)          nxt = ST_READY;
      end
      ST_READY: begin
        if (ctrl_wr && !wd_setup) nxt = ST_NORMAL;
        else if (ctrl_wr && wd_hv) nxt = ST_PULSE;
      end
      ST_PULSE: begin
        if ((ctrl_wr && !wd_hv) || stop_req || sys_rst) nxt = ST_MARGIN;
      end
      ST_MARGIN: begin
        if (ctrl_wr && !wd_setup) nxt = ST_NORMAL;
        else if (ctrl_wr && wd_hv) nxt = ST_PULSE;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  assign pulse_start = (nxt == ST_PULSE) && (state != ST_PULSE);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NORMAL;
    else     state <= nxt;
  end
endmodule

// File: rtl/flash_erase_regs.sv
module flash_erase_regs
  import flash_erase_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 2,
  parameter int PSW = 3
)(
  input  logic           clk,
  input  logic           rst,
  input  fe_state_t      state,
  input  logic           reg_wr,
  input  logic [RAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  input  logic           done,
  output logic [DW-1:0]  width,
  output logic [PSW-1:0] presc,
  output logic [DW-1:0]  reg_rdata
);
  localparam int PROTW = DW - CFG_PROT_LSB;

  logic             sel_q, setup_q;
  logic [PROTW-1:0] prot_q;
  logic             in_pulse, in_normal;

  assign in_pulse  = (state == ST_PULSE);
  assign in_normal = (state == ST_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      setup_q <= 1'b0;
      width   <= '0;
      presc   <= '0;
      prot_q  <= '0;
    end else if (reg_wr) begin
      if (addr == RAW'(OFS_CTRL) && !in_pulse) begin
        sel_q   <= wdata[CTRL_SEL_BIT];
        setup_q <= wdata[CTRL_SETUP_BIT];
      end
      if (addr == RAW'(OFS_WIDTH) && in_normal) width <= wdata;
      if (addr == RAW'(OFS_CFG) && in_normal) begin
        presc  <= wdata[PSW-1:0];
        prot_q <= wdata[DW-1:CFG_PROT_LSB];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (addr)
      RAW'(OFS_CTRL): begin
        reg_rdata[CTRL_SEL_BIT]   = sel_q;
        reg_rdata[CTRL_SETUP_BIT] = setup_q;
        reg_rdata[CTRL_HV_BIT]    = in_pulse;
      end
      RAW'(OFS_WIDTH): reg_rdata = width;
      RAW'(OFS_CFG): begin
        reg_rdata[PSW-1:0]           = presc;
        reg_rdata[DW-1:CFG_PROT_LSB] = prot_q;
      end
      default: begin
        reg_rdata[2:0]           = state;
        reg_rdata[STAT_DONE_BIT] = done;
      end
    endcase
  end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int CW  = 16,
  parameter int PSW = 3
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           active,
  input  logic [CW-1:0]  width,
  input  logic [PSW-1:0] presc,
  output logic           done
);
  logic [CW-1:0]  cnt;
  logic [PSW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pcnt <= '0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= width;
      pcnt <= '0;
      done <= 1'b0;
    end else if (active && presc != '0) begin
      if (cnt == '0) begin
        done <= 1'b1;
      end else if (pcnt == presc - PSW'(1)) begin
        pcnt <= '0;
        cnt  <= cnt - CW'(1);
      end else begin
        pcnt <= pcnt + PSW'(1);
      end
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 2,
  parameter int PSW = 3
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           sys_rst,
  input  logic           stop_req,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic           bus_space,
  input  logic [RAW-1:0] bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  arr_rdata,
  output logic [DW-1:0]  rd_data,
  output logic           rd_err,
  output logic           hv_en,
  output logic           array_busy,
  output logic           margin_mode,
  output logic [2:0]     state_o,
  output logic           pulse_done
);
  fe_state_t      state;
  logic           pulse_start;
  logic           reg_wr, ctrl_wr, arr_wr;
  logic [DW-1:0]  width, reg_rdata;
  logic [PSW-1:0] presc;

  assign reg_wr  = bus_wr && bus_space;
  assign ctrl_wr = reg_wr && (bus_addr == RAW'(OFS_CTRL));
  assign arr_wr  = bus_wr && !bus_space;

  flash_erase_fsm fsm_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr),
    .wd_hv(bus_wdata[CTRL_HV_BIT]), .wd_setup(bus_wdata[CTRL_SETUP_BIT]),
    .wd_sel(bus_wdata[CTRL_SEL_BIT]), .arr_wr(arr_wr),
    .stop_req(stop_req), .sys_rst(sys_rst),
    .state(state), .pulse_start(pulse_start)
  );

  flash_erase_regs #(.DW(DW), .RAW(RAW), .PSW(PSW)) regs_i (
    .clk(clk), .rst(rst), .state(state), .reg_wr(reg_wr),
    .addr(bus_addr), .wdata(bus_wdata), .done(pulse_done),
    .width(width), .presc(presc), .reg_rdata(reg_rdata)
  );

  flash_erase_timer #(.CW(DW), .PSW(PSW)) timer_i (
    .clk(clk), .rst(rst), .start(pulse_start),
    .active(state == ST_PULSE), .width(width), .presc(presc),
    .done(pulse_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rd_err <= 1'b0;
      if (bus_rd) begin
        if (bus_space) begin
          rd_data <= reg_rdata;
        end else if (state == ST_PULSE) begin
          rd_data <= '0;
          rd_err  <= 1'b1;
        end else begin
          rd_data <= arr_rdata;
        end
      end
    end
  end

  assign state_o     = state;
  assign hv_en       = (state == ST_PULSE);
  assign array_busy  = (state == ST_PULSE);
  assign margin_mode = (state == ST_MARGIN);
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
  parameter int DW  = 16,
  parameter int RAW = 2
)(
  input logic           clk,
  input logic           rst,
  input logic           stop_req,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic           bus_space,
  input logic [RAW-1:0] bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic           rd_err,
  input logic           hv_en,
  input logic           array_busy,
  input logic [2:0]     state_o,
  input logic           pulse_done
);
  logic cw;
  assign cw = bus_wr && bus_space && (bus_addr == '0);

  a_r2_arm: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && cw && bus_wdata[2] && bus_wdata[1]) |=> state_o == 3'd1);

  a_r3_hold_armed: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && bus_wr && bus_space && !(bus_addr == '0 && !bus_wdata[1]))
      |=> state_o == 3'd1);

  a_r4_no_hv_armed: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1) |=> !hv_en);

  a_r5_hv_busy: assert property (@(posedge clk) disable iff (rst)
    hv_en |-> (array_busy && state_o == 3'd3));

  a_r6_rd_err: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_space && state_o == 3'd3) |=> rd_err);

  a_r7_stop: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && stop_req) |=> state_o == 3'd4);

  a_r8_entry_src: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_en) |-> ($past(state_o) == 3'd2 || $past(state_o) == 3'd4));

  a_r9_mreset: assert property (@(posedge clk)
    rst |=> (state_o == 3'd0 && !hv_en));

  a_r11_done_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_en) |-> !pulse_done);
endmodule

bind flash_erase_seq flash_erase_chk #(.DW(DW), .RAW(RAW)) chk_i (
  .clk(clk), .rst(rst), .stop_req(stop_req), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_space(bus_space), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_err(rd_err), .hv_en(hv_en),
  .array_busy(array_busy), .state_o(state_o), .pulse_done(pulse_done)
);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sys_rst = 1'b0, stop_req = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_space = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] arr_rdata = 16'hA5C3;
  logic [15:0] rd_data;
  logic        rd_err, hv_en, array_busy, margin_mode, pulse_done;
  logic [2:0]  state_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_erase_seq dut_i (
    .clk(clk), .rst(rst), .sys_rst(sys_rst), .stop_req(stop_req),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .rd_err(rd_err), .hv_en(hv_en),
    .array_busy(array_busy), .margin_mode(margin_mode),
    .state_o(state_o), .pulse_done(pulse_done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sp, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_space = sp; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sp, input logic [1:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_space = sp; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic enter_pulse();
    wr(1, 2'd0, 16'h0006);
    wr(0, 2'd1, 16'h0000);
    wr(1, 2'd0, 16'h0007);
  endtask

  task automatic t_reset();
    check("R1 state", state_o, 0);
    check("R1 hv", hv_en, 0);
    check("R1 busy", array_busy, 0);
    check("R1 done", pulse_done, 0);
    rd(1, 2'd1);
    check("R1 width", rd_data, 0);
  endtask

  task automatic t_arm();
    wr(1, 2'd2, 16'h5A01);
    wr(1, 2'd1, 16'd10);
    rd(1, 2'd2);
    check("R10 cfg", rd_data, 16'h5A01);
    rd(0, 2'd0);
    check("R12 array read", rd_data, 16'hA5C3);
    wr(1, 2'd0, 16'h0006);
    check("R2 armed", state_o, 1);
    wr(1, 2'd0, 16'h0007);
    check("R4 state", state_o, 1);
    check("R4 hv", hv_en, 0);
    wr(1, 2'd1, 16'd99);
    check("R3 reg write keeps armed", state_o, 1);
    rd(1, 2'd1);
    check("R10 width ignored", rd_data, 16'd10);
    wr(0, 2'd2, 16'h1234);
    check("R3 ready", state_o, 2);
  endtask

  task automatic t_pulse();
    wr(1, 2'd0, 16'h0007);
    check("R5 state", state_o, 3);
    check("R5 hv", hv_en, 1);
    check("R5 busy", array_busy, 1);
    check("R11 done cleared", pulse_done, 0);
    repeat (9) @(negedge clk);
    check("R11 not yet done", pulse_done, 0);
    repeat (3) @(negedge clk);
    check("R11 done", pulse_done, 1);
    rd(0, 2'd0);
    check("R6 rd_err", rd_err, 1);
    wr(1, 2'd0, 16'h0001);
    check("R6 only hv changes", state_o, 3);
    rd(1, 2'd0);
    check("R12 ctrl", rd_data, 16'h0007);
    rd(1, 2'd3);
    check("R12 status", rd_data, 16'h0013);
    wr(1, 2'd0, 16'h0006);
    check("R7 hv0 margin", state_o, 4);
    check("R7 margin_mode", margin_mode, 1);
    check("R7 hv off", hv_en, 0);
    check("R11 sticky", pulse_done, 1);
    wr(1, 2'd0, 16'h0007);
    check("R8 repulse", state_o, 3);
    check("R11 cleared again", pulse_done, 0);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    check("R7 stop", state_o, 4);
    wr(1, 2'd0, 16'h0007);
    @(negedge clk); sys_rst = 1'b1;
    @(negedge clk); sys_rst = 1'b0;
    check("R7 sys_rst", state_o, 4);
    wr(1, 2'd0, 16'h0004);
    check("R9 margin abort", state_o, 0);
  endtask

  task automatic t_abort();
    wr(1, 2'd0, 16'h0006);
    wr(1, 2'd0, 16'h0000);
    check("R9 armed abort", state_o, 0);
    wr(1, 2'd0, 16'h0006);
    wr(0, 2'd0, 16'h0000);
    wr(1, 2'd0, 16'h0004);
    check("R9 ready abort", state_o, 0);
    enter_pulse();
    check("R9 pulse reached", state_o, 3);
    do_reset();
    check("R9 mreset", state_o, 0);
    check("R9 hv off", hv_en, 0);
    rd(1, 2'd1);
    check("R1 width after reset", rd_data, 0);
  endtask

  task automatic t_presc();
    wr(1, 2'd2, 16'h0000);
    wr(1, 2'd1, 16'd3);
    enter_pulse();
    repeat (40) @(negedge clk);
    check("R11 presc zero", pulse_done, 0);
    do_reset();
    wr(1, 2'd2, 16'h0003);
    wr(1, 2'd1, 16'd2);
    enter_pulse();
    repeat (5) @(negedge clk);
    check("R11 presc3 early", pulse_done, 0);
    repeat (4) @(negedge clk);
    check("R11 presc3 done", pulse_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_arm();
    t_pulse();
    t_abort();
    t_presc();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule